// File: doc/BRIEF.md
# Serial Byte Transceiver with Status Flags

This block is an asynchronous serial transmitter and receiver for byte-wide characters. A host reaches it through a small 16-bit register port with separate write and read strobes. Bit timing is taken from an external enable pulse, `tick16`, that runs at sixteen times the bit rate. The transmit side has a one-byte holding buffer in front of a shift register. It reports "buffer empty" and "shift register empty" as two separate flags. The receive side keeps one byte, plus a set of sticky error flags and an error-summary flag.

A transmit driver writes a byte whenever the buffer-empty flag is set. It knows the line has gone quiet only when both empty flags are set. A receive driver waits for receive-full or error-summary, then reads the data register. That read also clears the full flag and every error flag. One interrupt line is raised when any of four status sources is set and its mask bit is set.

Register map, selected by `bus_addr`: 0 = control, 1 = status (read only), 2 = interrupt mask, 3 = transmit data (write), 4 = receive data (read). Reads are combinational on `bus_rdata`. Only a read of address 4 with `bus_rd` high has a side effect.

Top module: `uart_flag_core`

## Requirements
- R1: After reset, status reads 0x0003 (both transmit empty flags set, nothing else), control and mask read 0, `irq` is low and `txd` is high.
- R2: A frame on `txd` is one low start bit, 8 data bits least-significant first, and one high stop bit. Each bit lasts 16 `tick16` pulses. A frame starts only while control bit 0 (transmit enable) is set.
- R3: Writing address 3 while status bit 0 (buffer empty) is set stores the byte and clears bit 0. Writing it while bit 0 is clear is ignored. A stored byte moves into the idle shift register when transmit is enabled, which sets bit 0 again and clears status bit 1 (shift register empty).
- R4: Status bit 1 stays clear for the whole frame and sets only after the stop bit. Transmission is complete only when bits 0 and 1 are both set.
- R5: Writing control with bit 2 set discards a byte waiting in the buffer and sets status bit 0. The discarded byte is never sent. Bit 2 reads back as 0.
- R6: The receiver takes each bit on the 8th of its 16 ticks, counted from the falling edge of the start bit. With control bit 1 (receive enable) clear, the line is ignored and no byte is received.
- R7: A received byte sets status bit 2 (receive full). Reading address 4 returns the byte in bits 7:0 and clears status bits 2 to 6.
- R8: A stop bit sampled low sets status bit 4 (framing error). The byte is still delivered, with bit 2 set.
- R9: A byte that completes while bit 2 is still set sets status bit 5 (overrun). The byte already held is kept.
- R10: Status bit 6 is set whenever any of bits 3, 4 or 5 is set. With the default setting (no parity), bit 3 (parity error) stays 0.
- R11: `irq` is the OR, over status bits 0, 1, 2 and 6, of the status bit ANDed with the same mask bit. Other mask bits are not stored and read back as 0.
- R12: If a byte completes in the same cycle as a read of address 4, the read returns the old byte, the new byte is kept with bit 2 set, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on receive data only) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Masked interrupt request |

## Verification
The collision that matters is a host read of the receive data register landing on the same clock edge as the completion of the next incoming byte. If the read's flag clearing won, that byte would be silently lost with no overrun. The bench provokes this by sweeping the read across every cycle around the expected end of a second frame, while a first byte is still held. Just before each read it samples the status register. If overrun was already set, the byte was lost legitimately; otherwise the receive-full flag and the new byte must both survive. A second pair that meets in one cycle is a byte write against the shift register taking the buffer. These cannot overlap, because a write is only accepted while the buffer is empty; the bench checks that writing to a full buffer leaves the waiting byte unchanged.

// File: rtl/ufc_pkg.sv
// Shared constants and types for the serial byte transceiver.
package ufc_pkg;
    localparam int ADDR_W = 3;
    localparam int REG_W  = 16;

    // Register addresses
    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 3'd0,
        ADDR_STAT = 3'd1,
        ADDR_MASK = 3'd2,
        ADDR_TXD  = 3'd3,
        ADDR_RXD  = 3'd4
    } ufc_addr_e;

    // Control bit positions
    localparam int CTL_TXEN = 0;
    localparam int CTL_RXEN = 1;
    localparam int CTL_TCLR = 2;

    // Status bit positions (mask uses the same positions)
    localparam int ST_TBE  = 0;
    localparam int ST_TSBE = 1;
    localparam int ST_RBF  = 2;
    localparam int ST_PAR  = 3;
    localparam int ST_FRM  = 4;
    localparam int ST_OVR  = 5;
    localparam int ST_SUM  = 6;

    localparam logic [REG_W-1:0] MASK_KEEP = 16'h0047;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } ufc_rx_state_e;
endpackage

// File: rtl/ufc_tx.sv
// Transmit shifter.
// Loads a byte from the holding buffer when idle and enabled, then sends
// start, data (LSB first), optional parity and stop, each OSR ticks long.
// Assumes tick_i is a single-cycle enable; enable only gates the start of a frame.
module ufc_tx #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int PARITY_MODE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 enable_i,
    input  logic                 load_valid_i,
    input  logic [DATA_BITS-1:0] load_data_i,
    output logic                 load_take_o,
    output logic                 busy_o,
    output logic                 txd_o
);
    localparam int PAR_W   = (PARITY_MODE != 0) ? 1 : 0;
    localparam int FRAME_W = DATA_BITS + PAR_W + 2;
    localparam int CNT_W   = $clog2(OSR);
    localparam int BIT_W   = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame_img;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   tick_cnt;
    logic [BIT_W-1:0]   bits_left;

    // Frame image: stop, optional parity, data, start (LSB goes out first)
    generate
        if (PARITY_MODE == 0) begin : g_nopar
            assign frame_img = {1'b1, load_data_i, 1'b0};
        end else begin : g_par
            logic par_bit;
            assign par_bit   = (PARITY_MODE == 2) ? ~(^load_data_i) : ^load_data_i;
            assign frame_img = {1'b1, par_bit, load_data_i, 1'b0};
        end
    endgenerate

    assign load_take_o = !busy_o && enable_i && load_valid_i;
    assign txd_o       = busy_o ? shreg[0] : 1'b1;

    // Shift sequencing: load on take, advance one bit every OSR ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            shreg     <= '1;
            tick_cnt  <= '0;
            bits_left <= '0;
        end else if (!busy_o) begin
            if (load_take_o) begin
                busy_o    <= 1'b1;
                shreg     <= frame_img;
                tick_cnt  <= '0;
                bits_left <= BIT_W'(FRAME_W - 1);
            end
        end else if (tick_i) begin
            if (tick_cnt == CNT_W'(OSR - 1)) begin
                tick_cnt <= '0;
                if (bits_left == '0) begin
                    busy_o <= 1'b0;
                end else begin
                    shreg     <= {1'b1, shreg[FRAME_W-1:1]};
                    bits_left <= bits_left - 1'b1;
                end
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ufc_rx.sv
// Receive sampler.
// Synchronises the line, detects a falling edge as start, and samples each
// bit at tick count OSR/2-1 (the 8th of 16). Emits a one-cycle done pulse
// with the byte and its error bits. Aborts to idle when enable drops.
module ufc_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int PARITY_MODE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 enable_i,
    input  logic                 rxd_i,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 frm_err_o,
    output logic                 par_err_o
);
    import ufc_pkg::*;

    localparam int CNT_W     = $clog2(OSR);
    localparam int SAMPLE_AT = OSR / 2 - 1;
    localparam int BC_W      = $clog2(DATA_BITS + 1);

    ufc_rx_state_e        state;
    logic [1:0]           sync_q;
    logic                 rx_s;
    logic                 rx_prev;
    logic [CNT_W-1:0]     tcnt;
    logic [BC_W-1:0]      bcnt;
    logic [DATA_BITS-1:0] sh;
    logic                 par_q;
    logic                 par_bad;

    assign rx_s = sync_q[1];

    // Two-flop synchroniser and previous-value register for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            rx_prev <= 1'b1;
        end else begin
            sync_q  <= {sync_q[0], rxd_i};
            rx_prev <= rx_s;
        end
    end

    // Parity check against the received data, per configured mode
    always_comb begin
        if (PARITY_MODE == 1)      par_bad = par_q ^ (^sh);
        else if (PARITY_MODE == 2) par_bad = par_q ^ ~(^sh);
        else                       par_bad = 1'b0;
    end

    // Frame state machine with mid-bit sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            tcnt      <= '0;
            bcnt      <= '0;
            sh        <= '0;
            par_q     <= 1'b0;
            done_o    <= 1'b0;
            data_o    <= '0;
            frm_err_o <= 1'b0;
            par_err_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!enable_i) begin
                state <= RX_IDLE;
            end else if (state == RX_IDLE) begin
                if (rx_prev && !rx_s) begin
                    state <= RX_START;
                    tcnt  <= '0;
                end
            end else if (tick_i) begin
                tcnt <= (tcnt == CNT_W'(OSR - 1)) ? '0 : tcnt + 1'b1;
                if (tcnt == CNT_W'(SAMPLE_AT)) begin
                    case (state)
                        RX_START: begin
                            if (rx_s) begin
                                state <= RX_IDLE;
                            end else begin
                                state <= RX_DATA;
                                bcnt  <= '0;
                            end
                        end
                        RX_DATA: begin
                            sh   <= {rx_s, sh[DATA_BITS-1:1]};
                            bcnt <= bcnt + 1'b1;
                            if (bcnt == BC_W'(DATA_BITS - 1))
                                state <= (PARITY_MODE != 0) ? RX_PAR : RX_STOP;
                        end
                        RX_PAR: begin
                            par_q <= rx_s;
                            state <= RX_STOP;
                        end
                        RX_STOP: begin
                            done_o    <= 1'b1;
                            data_o    <= sh;
                            frm_err_o <= !rx_s;
                            par_err_o <= par_bad;
                            state     <= RX_IDLE;
                        end
                        default: state <= RX_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ufc_regs.sv
// Register file and flags.
// Holds control, mask, the transmit holding buffer and the received byte
// with its sticky error flags; builds the status word and the read mux.
// Assumes tx_take_i only fires while the buffer is full.
module ufc_regs #(
    parameter int DATA_BITS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ufc_pkg::ADDR_W-1:0] addr_i,
    input  logic                     wr_i,
    input  logic                     rd_fire_i,
    input  logic [ufc_pkg::REG_W-1:0]  wdata_i,
    output logic [ufc_pkg::REG_W-1:0]  rdata_o,
    output logic                     tx_en_o,
    output logic                     rx_en_o,
    output logic                     buf_full_o,
    output logic [DATA_BITS-1:0]     buf_data_o,
    input  logic                     tx_take_i,
    input  logic                     tx_busy_i,
    input  logic                     rx_done_i,
    input  logic [DATA_BITS-1:0]     rx_data_i,
    input  logic                     rx_frm_i,
    input  logic                     rx_par_i,
    output logic [ufc_pkg::REG_W-1:0]  stat_o,
    output logic [ufc_pkg::REG_W-1:0]  mask_o,
    output logic [DATA_BITS-1:0]     rx_hold_o
);
    import ufc_pkg::*;

    logic wr_ctrl, wr_mask, wr_txd;
    logic rbf_q, pe_q, fe_q, ove_q;
    logic keep_old;

    assign wr_ctrl  = wr_i && (addr_i == ADDR_CTRL);
    assign wr_mask  = wr_i && (addr_i == ADDR_MASK);
    assign wr_txd   = wr_i && (addr_i == ADDR_TXD);
    assign keep_old = rbf_q && !rd_fire_i;

    // Control and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_o <= 1'b0;
            rx_en_o <= 1'b0;
            mask_o  <= '0;
        end else begin
            if (wr_ctrl) begin
                tx_en_o <= wdata_i[CTL_TXEN];
                rx_en_o <= wdata_i[CTL_RXEN];
            end
            if (wr_mask) mask_o <= wdata_i & MASK_KEEP;
        end
    end

    // Transmit holding buffer: accept only when empty, drop on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full_o <= 1'b0;
            buf_data_o <= '0;
        end else if (wr_ctrl && wdata_i[CTL_TCLR]) begin
            buf_full_o <= 1'b0;
        end else if (tx_take_i) begin
            buf_full_o <= 1'b0;
        end else if (wr_txd && !buf_full_o) begin
            buf_full_o <= 1'b1;
            buf_data_o <= wdata_i[DATA_BITS-1:0];
        end
    end

    // Receive byte and sticky errors; completion outranks a same-cycle read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbf_q     <= 1'b0;
            pe_q      <= 1'b0;
            fe_q      <= 1'b0;
            ove_q     <= 1'b0;
            rx_hold_o <= '0;
        end else if (rx_done_i && !keep_old) begin
            rbf_q     <= 1'b1;
            rx_hold_o <= rx_data_i;
            fe_q      <= rx_frm_i;
            pe_q      <= rx_par_i;
            ove_q     <= 1'b0;
        end else if (rx_done_i) begin
            ove_q <= 1'b1;
        end else if (rd_fire_i) begin
            rbf_q <= 1'b0;
            pe_q  <= 1'b0;
            fe_q  <= 1'b0;
            ove_q <= 1'b0;
        end
    end

    // Status word
    always_comb begin
        stat_o          = '0;
        stat_o[ST_TBE]  = !buf_full_o;
        stat_o[ST_TSBE] = !tx_busy_i;
        stat_o[ST_RBF]  = rbf_q;
        stat_o[ST_PAR]  = pe_q;
        stat_o[ST_FRM]  = fe_q;
        stat_o[ST_OVR]  = ove_q;
        stat_o[ST_SUM]  = pe_q | fe_q | ove_q;
    end

    // Read mux
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CTRL: begin
                rdata_o[CTL_TXEN] = tx_en_o;
                rdata_o[CTL_RXEN] = rx_en_o;
            end
            ADDR_STAT: rdata_o = stat_o;
            ADDR_MASK: rdata_o = mask_o;
            ADDR_RXD:  rdata_o = REG_W'(rx_hold_o);
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/uart_flag_core.sv
// Top of the serial byte transceiver: register file, transmit shifter,
// receive sampler and the masked interrupt. Assumes tick16 pulses at OSR
// times the bit rate and that DATA_BITS fits the 16-bit data register.
module uart_flag_core #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int PARITY_MODE = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick16,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq
);
    import ufc_pkg::*;

    logic                 tx_en, rx_en;
    logic                 buf_full;
    logic [DATA_BITS-1:0] buf_data;
    logic                 tx_take, tx_busy;
    logic                 rx_done, rx_frm, rx_par;
    logic [DATA_BITS-1:0] rx_data;
    logic [DATA_BITS-1:0] rx_hold;
    logic [REG_W-1:0]     stat_vec, mask_vec;
    logic                 rd_fire;

    assign rd_fire = bus_rd && (bus_addr == ADDR_RXD);
    assign irq     = |(stat_vec & mask_vec & MASK_KEEP);

    ufc_regs #(.DATA_BITS(DATA_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr_i(bus_addr), .wr_i(bus_wr), .rd_fire_i(rd_fire),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .tx_en_o(tx_en), .rx_en_o(rx_en),
        .buf_full_o(buf_full), .buf_data_o(buf_data),
        .tx_take_i(tx_take), .tx_busy_i(tx_busy),
        .rx_done_i(rx_done), .rx_data_i(rx_data),
        .rx_frm_i(rx_frm), .rx_par_i(rx_par),
        .stat_o(stat_vec), .mask_o(mask_vec), .rx_hold_o(rx_hold)
    );

    ufc_tx #(.DATA_BITS(DATA_BITS), .OSR(OSR), .PARITY_MODE(PARITY_MODE)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16), .enable_i(tx_en),
        .load_valid_i(buf_full), .load_data_i(buf_data),
        .load_take_o(tx_take), .busy_o(tx_busy), .txd_o(txd)
    );

    ufc_rx #(.DATA_BITS(DATA_BITS), .OSR(OSR), .PARITY_MODE(PARITY_MODE)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16), .enable_i(rx_en),
        .rxd_i(rxd), .done_o(rx_done), .data_o(rx_data),
        .frm_err_o(rx_frm), .par_err_o(rx_par)
    );
endmodule

// File: rtl/ufc_checker.sv
// Property checker for uart_flag_core, attached by bind below.
// Observes the flags, the shifter handshake and the receive completion.
module ufc_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 txd,
    input logic                 irq,
    input logic                 tx_busy,
    input logic                 buf_full,
    input logic                 tx_en,
    input logic                 rx_en,
    input logic                 rx_done,
    input logic                 rx_frm,
    input logic                 rd_fire,
    input logic [15:0]          stat,
    input logic [15:0]          mask,
    input logic [DATA_BITS-1:0] rx_hold
);
    // R2: a frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    // R3: waiting byte moves into the idle shifter when enabled
    a_r3_take: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !tx_busy && tx_en) |=> (tx_busy && stat[0] && !stat[1]));

    // R4: shifter goes empty only after a high stop bit
    a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> $past(txd));

    // R6: disabled receiver completes nothing
    a_r6_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_done);

    // R7: data read with no completion clears full and all errors
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !rx_done) |=> (stat[6:2] == 5'b0));

    // R8: framing error still delivers the byte
    a_r8_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_frm && !(stat[2] && !rd_fire)) |=> (stat[4] && stat[2]));

    // R9: overrun keeps the old byte
    a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && stat[2] && !rd_fire) |=> (stat[5] && stat[2] && $stable(rx_hold)));

    // R11: enabled receive-full raises the interrupt
    a_r11_irq_rbf: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[2] && mask[2]) |-> irq);

    // R12: completion on the same edge as a read is kept
    a_r12_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rd_fire) |=> (stat[2] && !stat[5]));
endmodule

bind uart_flag_core ufc_checker #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .irq(irq),
    .tx_busy(tx_busy), .buf_full(buf_full), .tx_en(tx_en), .rx_en(rx_en),
    .rx_done(rx_done), .rx_frm(rx_frm), .rd_fire(rd_fire),
    .stat(stat_vec), .mask(mask_vec), .rx_hold(rx_hold)
);

// File: tb/uart_flag_core_tb.sv
module uart_flag_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        txd, irq;
    logic        drv_rxd = 1'b1;
    logic        loop_en = 1'b0;
    logic        dut_rxd;
    int          div = 1;
    int          div_cnt = 0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_MASK = 3'd2,
                           A_TXD = 3'd3, A_RXD = 3'd4;

    assign dut_rxd = loop_en ? txd : drv_rxd;

    uart_flag_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(dut_rxd), .txd(txd), .irq(irq)
    );

    always #5 clk = ~clk;

    // 16x tick generator, one pulse every div cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= 0;
            tick16  <= 1'b0;
        end else if (div_cnt >= div - 1) begin
            div_cnt <= 0;
            tick16  <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1;
            tick16  <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rx_read(output logic [15:0] v);
        @(negedge clk);
        bus_addr = A_RXD; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_bit);
        @(negedge clk);
        drv_rxd = 1'b0;
        repeat (16 * div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            drv_rxd = b[i];
            repeat (16 * div) @(negedge clk);
        end
        drv_rxd = stop_bit;
        repeat (16 * div) @(negedge clk);
        drv_rxd = 1'b1;
    endtask

    task automatic tx_decode(output logic [7:0] b, output logic ok);
        bit found = 1'b0;
        ok = 1'b1;
        b  = 8'h00;
        for (int n = 0; n < 4000 && !found; n++) begin
            @(negedge clk);
            if (txd === 1'b0) found = 1'b1;
        end
        if (!found) ok = 1'b0;
        else begin
            repeat (8 * div) @(negedge clk);
            if (txd !== 1'b0) ok = 1'b0;
            for (int i = 0; i < 8; i++) begin
                repeat (16 * div) @(negedge clk);
                b[i] = txd;
            end
            repeat (16 * div) @(negedge clk);
            if (txd !== 1'b1) ok = 1'b0;
        end
    endtask

    task automatic count_lows(input int cycles, output int lows);
        lows = 0;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            if (txd === 1'b0) lows++;
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v, pre, got;
        logic [7:0]  b;
        logic        ok;
        int          lows;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(A_STAT, v); chk("R1 status", v, 16'h0003);
        peek(A_CTRL, v); chk("R1 control", v, 16'h0000);
        peek(A_MASK, v); chk("R1 mask", v, 16'h0000);
        chk("R1 irq", irq, 1'b0);
        chk("R1 txd", txd, 1'b1);

        // R11: mask keeps only bits 0,1,2,6
        reg_wr(A_MASK, 16'hFFFF);
        peek(A_MASK, v); chk("R11 mask readback", v, 16'h0047);
        reg_wr(A_MASK, 16'h0001);
        peek(A_STAT, v); chk("R11 irq tbe", irq, 1'b1);
        reg_wr(A_MASK, 16'h0000);
        peek(A_STAT, v); chk("R11 irq masked", irq, 1'b0);

        // R3: write to full buffer ignored; R5 clear bit reads 0
        reg_wr(A_CTRL, 16'h0000);
        reg_wr(A_TXD, 16'h003C);
        peek(A_STAT, v); chk("R3 tbe cleared", v, 16'h0002);
        reg_wr(A_TXD, 16'h00C3);
        reg_wr(A_CTRL, 16'h0001);
        tx_decode(b, ok);
        chk("R3 first byte kept", {ok, b}, {1'b1, 8'h3C});
        repeat (20) @(negedge clk);
        count_lows(200, lows);
        chk("R3 ignored byte not sent", lows, 0);
        peek(A_STAT, v); chk("R4 idle both empty", v, 16'h0003);

        // R5: clear discards waiting byte
        reg_wr(A_CTRL, 16'h0000);
        reg_wr(A_TXD, 16'h0077);
        reg_wr(A_CTRL, 16'h0004);
        peek(A_STAT, v); chk("R5 tbe after clear", v, 16'h0003);
        peek(A_CTRL, v); chk("R5 clear reads 0", v, 16'h0000);
        reg_wr(A_CTRL, 16'h0001);
        count_lows(200, lows);
        chk("R5 nothing sent", lows, 0);

        // R4: buffer empty before shifter empty, interrupts per flag
        reg_wr(A_MASK, 16'h0002);
        reg_wr(A_TXD, 16'h005A);
        repeat (4) @(negedge clk);
        peek(A_STAT, v); chk("R4 mid frame", v, 16'h0001);
        chk("R11 irq tsbe low", irq, 1'b0);
        reg_wr(A_MASK, 16'h0001);
        peek(A_STAT, v); chk("R11 irq tbe mid frame", irq, 1'b1);
        reg_wr(A_MASK, 16'h0002);
        repeat (200) @(negedge clk);
        peek(A_STAT, v); chk("R4 end of frame", v, 16'h0003);
        chk("R11 irq tsbe", irq, 1'b1);
        reg_wr(A_MASK, 16'h0000);

        // R2: slower tick, bit length follows the tick
        div = 3;
        repeat (10) @(negedge clk);
        reg_wr(A_TXD, 16'h0096);
        tx_decode(b, ok);
        chk("R2 frame at div 3", {ok, b}, {1'b1, 8'h96});
        repeat (80) @(negedge clk);
        div = 1;
        repeat (10) @(negedge clk);

        // R6: receiver disabled ignores the line
        send_frame(8'hA5, 1'b1);
        repeat (20) @(negedge clk);
        peek(A_STAT, v); chk("R6 rx off", v, 16'h0003);

        // R8, R10: framing error
        reg_wr(A_CTRL, 16'h0003);
        send_frame(8'hE1, 1'b0);
        repeat (20) @(negedge clk);
        peek(A_STAT, v); chk("R8 framing status", v, 16'h0057);
        reg_wr(A_MASK, 16'h0038);
        peek(A_STAT, v); chk("R11 unmaskable bits", irq, 1'b0);
        reg_wr(A_MASK, 16'h0040);
        peek(A_STAT, v); chk("R10 summary irq", irq, 1'b1);
        reg_wr(A_MASK, 16'h0000);
        rx_read(v); chk("R8 byte delivered", v, 16'h00E1);
        peek(A_STAT, v); chk("R7 cleared after read", v, 16'h0003);

        // R9: overrun keeps the first byte
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        repeat (20) @(negedge clk);
        peek(A_STAT, v); chk("R9 overrun status", v, 16'h0067);
        rx_read(v); chk("R9 old byte kept", v, 16'h0011);
        peek(A_STAT, v); chk("R9 cleared", v, 16'h0003);

        // R2, R6, R7: loopback sweep over every byte value
        loop_en = 1'b1;
        for (int x = 0; x < 256; x++) begin
            reg_wr(A_TXD, 16'(x));
            tx_decode(b, ok);
            chk("R2 loop tx", {ok, b}, {1'b1, 8'(x)});
            repeat (24) @(negedge clk);
            peek(A_STAT, v); chk("R7 loop full", v, 16'h0007);
            rx_read(v); chk("R6 loop rx", v, 16'(x));
        end
        loop_en = 1'b0;
        repeat (10) @(negedge clk);

        // R12: read swept across completion of a second byte
        for (int k = 140; k <= 170; k++) begin
            rx_read(v);
            send_frame(8'h3A, 1'b1);
            fork
                send_frame(8'hC5, 1'b1);
                begin
                    repeat (k) @(negedge clk);
                    bus_addr = A_STAT;
                    #1 pre = bus_rdata;
                    bus_addr = A_RXD;
                    bus_rd = 1'b1;
                    #1 got = bus_rdata;
                    @(negedge clk);
                    bus_rd = 1'b0;
                end
            join
            repeat (20) @(negedge clk);
            chk("R12 read returns old", got, 16'h003A);
            peek(A_STAT, v);
            if (pre[5]) begin
                chk("R12 lost after overrun", v[2], 1'b0);
            end else begin
                chk("R12 new byte kept", v, 16'h0007);
                rx_read(v); chk("R12 new byte value", v, 16'h00C5);
            end
        end

        finished = 1'b1;
        finish_run();
    end
endmodule